// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block holds the fetch address state of several hardware threads and hands out one fetch address and one sequence number per accepted assign request. Each thread has a current fetch PC. The two following addresses are one and two instruction sizes above it. The block also has a small delay-slot tracker, so a branch redirect is applied only after the instruction in the branch's delay slot has been handed out.

A later pipeline stage sends prediction results for resolved control instructions on the update port. A predicted-taken branch arms the tracker and asks for younger work to be flushed. A return with no predicted address stops fetch for its thread until a flush supplies the address. Flush (squash) redirects arrive on several ports in the same cycle. For each thread, the oldest one wins. Threads are brought up with an activate command carrying a start PC, and taken down with a deactivate command.

Top module: `fps_seq`

## Requirements
- R1: After reset every thread is stalled (`stall` all ones) and every blocked-stage field is 0. The field for thread t is `blk_stage[t*STAGE_W +: STAGE_W]`.
- R2: An activate command loads the thread's PC from `act_pc` and clears its stall bit on the next cycle.
- R3: A completed assign (`asg_valid && asg_ready`) returns the PC on `asg_pc`, PC+INSN_BYTES on `asg_npc`, PC+2*INSN_BYTES on `asg_nnpc`, and the thread's sequence number on `asg_seq`. The PC then advances by INSN_BYTES and the per-thread sequence counter (reset 0) increments by one.
- R4: An assign to a stalled thread has `asg_ready` low, does not move the PC and consumes no sequence number.
- R5: An update for a control instruction predicted taken drives `sqo_valid` in the same cycle, with `sqo_seq` = branch sequence + 1 and `sqo_target` = predicted target. The next assign returns the sequential (delay-slot) address. The assign after that returns the predicted target.
- R6: An update for a control instruction predicted not-taken with an unconditional delay slot raises no squash request. It redirects to the branch PC + 2*INSN_BYTES after the delay slot, which keeps the fetch stream sequential.
- R7: An update for a conditional delay-slot control instruction predicted not-taken drives `sqo_seq` = branch sequence and `sqo_target` = `upd_target`, and leaves the fetch state unchanged.
- R8: An update with `upd_ctrl` low raises no squash request and has no effect on the fetch stream.
- R9: An update for a return not predicted taken stalls its thread and records `upd_stage` in that thread's blocked-stage field.
- R10: An accepted squash whose sequence number differs from the thread's next sequence number reloads the PC with the squash target. It clears the stall bit, and `unblk[t]` is high in that cycle only if the thread was stalled.
- R11: An accepted squash whose sequence number equals the thread's next sequence number keeps the PC for one more assign (the delay slot). The assign after that returns the squash target.
- R12: Squash port p uses `sq_tid[p*TID_W +: TID_W]`, `sq_seq[p*SEQ_W +: SEQ_W]` and `sq_target[p*ADDR_W +: ADDR_W]`. Among squashes for one thread in one cycle, the smallest sequence number is accepted. On equal numbers, the lower port wins. Squashes for different threads are all accepted.
- R13: A squash to a thread in the same cycle as an assign or update to it wins: `asg_ready` and `upd_ready` are low for that thread.
- R14: Deactivating a thread stalls it, sets its blocked-stage field to 0 and discards any pending delay-slot redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| act_valid | input | 1 | Activate a thread |
| act_tid | input | TID_W | Thread to activate |
| act_pc | input | ADDR_W | Start PC for activation |
| deact_valid | input | 1 | Deactivate a thread |
| deact_tid | input | TID_W | Thread to deactivate |
| asg_valid | input | 1 | Assign request |
| asg_tid | input | TID_W | Thread of the assign request |
| asg_ready | output | 1 | Assign completes this cycle |
| asg_pc | output | ADDR_W | Assigned fetch PC |
| asg_npc | output | ADDR_W | Assigned PC + one instruction |
| asg_nnpc | output | ADDR_W | Assigned PC + two instructions |
| asg_seq | output | SEQ_W | Assigned sequence number |
| upd_valid | input | 1 | Prediction update request |
| upd_tid | input | TID_W | Thread of the update |
| upd_ready | output | 1 | Update accepted this cycle |
| upd_ctrl | input | 1 | Instruction is a control transfer |
| upd_ret | input | 1 | Instruction is a return |
| upd_taken | input | 1 | Predicted taken |
| upd_cond | input | 1 | Conditional delay-slot control |
| upd_seq | input | SEQ_W | Sequence number of the instruction |
| upd_pc | input | ADDR_W | PC of the instruction |
| upd_target | input | ADDR_W | Predicted target |
| upd_stage | input | STAGE_W | Stage issuing the update |
| sqo_valid | output | 1 | Squash request produced by an update |
| sqo_tid | output | TID_W | Thread of the squash request |
| sqo_seq | output | SEQ_W | Flush everything younger than this |
| sqo_target | output | ADDR_W | Redirect address of the request |
| sq_valid | input | NSQ | Squash inputs, one bit per port |
| sq_tid | input | NSQ*TID_W | Thread of each squash port |
| sq_seq | input | NSQ*SEQ_W | Sequence number of each squash port |
| sq_target | input | NSQ*ADDR_W | Target of each squash port |
| stall | output | NT | Per-thread fetch stall |
| blk_stage | output | NT*STAGE_W | Per-thread stage that blocked fetch |
| unblk | output | NT | Per-thread unblock pulse |

## Verification
The bench builds the block with its defaults: four threads, two squash ports, eight stages, 32-bit addresses and sequence numbers, 4-byte instructions. With four threads, interleaved assign streams can be checked on every thread at once. With eight stages, the bench can sweep every blocked-stage value through a return-stall and squash-release loop. With two squash ports, it can drive older-first, tie and cross-thread pairs in one cycle. Expected addresses are computed as base plus four times the assign count, and expected sequence numbers come from a per-thread count kept by the bench.

// File: rtl/fps_pkg.sv
// Package: shared decode of a prediction update into the action it triggers.
// Assumes the update flags are meaningful only when the control flag is set.
package fps_pkg;

    typedef enum logic [2:0] {
        UPD_NONE,       // no change to fetch state
        UPD_RET_BLOCK,  // return with unknown address: stop fetch
        UPD_COND_SKIP,  // conditional not-taken: flush after the branch
        UPD_NT_SLOT,    // not-taken with delay slot: arm fall-through
        UPD_TAKEN       // taken: arm target and flush after the slot
    } upd_kind_e;

    // Map the update flags onto one action, return check first.
    function automatic upd_kind_e classify(input logic ctrl, input logic ret,
                                           input logic taken, input logic cond);
        if (!ctrl)               return UPD_NONE;
        else if (ret && !taken)  return UPD_RET_BLOCK;
        else if (taken)          return UPD_TAKEN;
        else if (cond)           return UPD_COND_SKIP;
        else                     return UPD_NT_SLOT;
    endfunction

endpackage

// File: rtl/fps_sq_pick.sv
// Squash picker: for each thread, selects the oldest (smallest sequence)
// squash among all ports this cycle; a tie goes to the lower port.
// Assumes port fields are packed contiguously, port 0 in the low bits.
module fps_sq_pick #(
    parameter int NT     = 4,
    parameter int NSQ    = 2,
    parameter int SEQ_W  = 32,
    parameter int ADDR_W = 32,
    localparam int TID_W = $clog2(NT)
) (
    input  logic [NSQ-1:0]        sq_valid_i,
    input  logic [NSQ*TID_W-1:0]  sq_tid_i,
    input  logic [NSQ*SEQ_W-1:0]  sq_seq_i,
    input  logic [NSQ*ADDR_W-1:0] sq_tgt_i,
    output logic [NT-1:0]         hit_o,
    output logic [NT*SEQ_W-1:0]   seq_o,
    output logic [NT*ADDR_W-1:0]  tgt_o
);
    for (genvar t = 0; t < NT; t++) begin : g_thr
        // Scan the ports in order, keeping a strictly older candidate only.
        always_comb begin
            hit_o[t]                    = 1'b0;
            seq_o[t*SEQ_W +: SEQ_W]     = '0;
            tgt_o[t*ADDR_W +: ADDR_W]   = '0;
            for (int p = 0; p < NSQ; p++) begin
                if (sq_valid_i[p] && sq_tid_i[p*TID_W +: TID_W] == TID_W'(t) &&
                    (!hit_o[t] || sq_seq_i[p*SEQ_W +: SEQ_W] < seq_o[t*SEQ_W +: SEQ_W])) begin
                    hit_o[t]                  = 1'b1;
                    seq_o[t*SEQ_W +: SEQ_W]   = sq_seq_i[p*SEQ_W +: SEQ_W];
                    tgt_o[t*ADDR_W +: ADDR_W] = sq_tgt_i[p*ADDR_W +: ADDR_W];
                end
            end
        end
    end
endmodule

// File: rtl/fps_thread.sv
// Per-thread fetch state: PC, sequence counter, delay-slot tracker and
// block state. Command priority: deactivate, activate, squash, then
// assign and update together. Assumes fire inputs are already qualified.
module fps_thread
    import fps_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SEQ_W      = 32,
    parameter int STAGE_W    = 3,
    parameter int CNT_W      = 2,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_i,
    input  logic [ADDR_W-1:0]  act_pc_i,
    input  logic               deact_i,
    input  logic               asg_i,
    input  logic               upd_i,
    input  upd_kind_e          upd_kind_i,
    input  logic [ADDR_W-1:0]  upd_pc_i,
    input  logic [ADDR_W-1:0]  upd_tgt_i,
    input  logic [STAGE_W-1:0] upd_stage_i,
    input  logic               sq_i,
    input  logic [SEQ_W-1:0]   sq_seq_i,
    input  logic [ADDR_W-1:0]  sq_tgt_i,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [SEQ_W-1:0]   seq_o,
    output logic               valid_o,
    output logic [STAGE_W-1:0] stage_o,
    output logic               unblk_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0]  pc_q, tgt_q;
    logic [SEQ_W-1:0]   seq_q;
    logic [CNT_W-1:0]   cnt_q, cnt_mid;
    logic               rdy_q, valid_q, redirect;
    logic [STAGE_W-1:0] stage_q;

    // Redirect to the armed target once no delay slot is outstanding.
    assign redirect = rdy_q && (cnt_q == '0);
    assign pc_o     = redirect ? tgt_q : pc_q;
    assign seq_o    = seq_q;
    assign valid_o  = valid_q;
    assign stage_o  = stage_q;
    assign unblk_o  = sq_i && !deact_i && !act_i && !valid_q;

    // Pending count after this cycle's assign, before any update adds to it.
    always_comb cnt_mid = (asg_i && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;

    // State update in command priority order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            tgt_q   <= '0;
            seq_q   <= '0;
            cnt_q   <= '0;
            rdy_q   <= 1'b0;
            valid_q <= 1'b0;
            stage_q <= '0;
        end else if (deact_i) begin
            valid_q <= 1'b0;
            cnt_q   <= '0;
            rdy_q   <= 1'b0;
            stage_q <= '0;
        end else if (act_i) begin
            valid_q <= 1'b1;
            pc_q    <= act_pc_i;
            cnt_q   <= '0;
            rdy_q   <= 1'b0;
        end else if (sq_i) begin
            valid_q <= 1'b1;
            rdy_q   <= 1'b0;
            if (sq_seq_i == seq_q) begin
                cnt_q <= CNT_W'(1);
                tgt_q <= sq_tgt_i;
            end else begin
                cnt_q <= '0;
                pc_q  <= sq_tgt_i;
            end
        end else begin
            if (asg_i) begin
                pc_q  <= pc_o + STEP;
                seq_q <= seq_q + 1'b1;
                cnt_q <= cnt_mid;
                if (cnt_q != '0) rdy_q <= (cnt_q == CNT_W'(1));
                else if (redirect) rdy_q <= 1'b0;
            end
            if (upd_i) begin
                case (upd_kind_i)
                    UPD_RET_BLOCK: begin
                        valid_q <= 1'b0;
                        stage_q <= upd_stage_i;
                    end
                    UPD_NT_SLOT: begin
                        cnt_q <= cnt_mid + 1'b1;
                        rdy_q <= 1'b0;
                        tgt_q <= upd_pc_i + STEP + STEP;
                    end
                    UPD_TAKEN: begin
                        cnt_q <= cnt_mid + 1'b1;
                        rdy_q <= 1'b0;
                        tgt_q <= upd_tgt_i;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fps_seq.sv
// Top: multithreaded fetch PC sequencer. Routes commands to per-thread
// state, qualifies assign and update against same-thread squashes and
// thread commands, and forms the squash request from an update.
// Assumes NT is a power of two greater than one.
module fps_seq
    import fps_pkg::*;
#(
    parameter int NT         = 4,
    parameter int NSQ        = 2,
    parameter int ADDR_W     = 32,
    parameter int SEQ_W      = 32,
    parameter int STAGE_W    = 3,
    parameter int CNT_W      = 2,
    parameter int INSN_BYTES = 4,
    localparam int TID_W     = $clog2(NT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  act_valid,
    input  logic [TID_W-1:0]      act_tid,
    input  logic [ADDR_W-1:0]     act_pc,
    input  logic                  deact_valid,
    input  logic [TID_W-1:0]      deact_tid,
    input  logic                  asg_valid,
    input  logic [TID_W-1:0]      asg_tid,
    output logic                  asg_ready,
    output logic [ADDR_W-1:0]     asg_pc,
    output logic [ADDR_W-1:0]     asg_npc,
    output logic [ADDR_W-1:0]     asg_nnpc,
    output logic [SEQ_W-1:0]      asg_seq,
    input  logic                  upd_valid,
    input  logic [TID_W-1:0]      upd_tid,
    output logic                  upd_ready,
    input  logic                  upd_ctrl,
    input  logic                  upd_ret,
    input  logic                  upd_taken,
    input  logic                  upd_cond,
    input  logic [SEQ_W-1:0]      upd_seq,
    input  logic [ADDR_W-1:0]     upd_pc,
    input  logic [ADDR_W-1:0]     upd_target,
    input  logic [STAGE_W-1:0]    upd_stage,
    output logic                  sqo_valid,
    output logic [TID_W-1:0]      sqo_tid,
    output logic [SEQ_W-1:0]      sqo_seq,
    output logic [ADDR_W-1:0]     sqo_target,
    input  logic [NSQ-1:0]        sq_valid,
    input  logic [NSQ*TID_W-1:0]  sq_tid,
    input  logic [NSQ*SEQ_W-1:0]  sq_seq,
    input  logic [NSQ*ADDR_W-1:0] sq_target,
    output logic [NT-1:0]         stall,
    output logic [NT*STAGE_W-1:0] blk_stage,
    output logic [NT-1:0]         unblk
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [NT-1:0]        sq_hit, thr_valid, act_sel, deact_sel, busy;
    logic [NT*SEQ_W-1:0]  sq_seq_t;
    logic [NT*ADDR_W-1:0] sq_tgt_t;
    logic [ADDR_W-1:0]    pc_t  [NT];
    logic [SEQ_W-1:0]     seq_t [NT];
    logic                 asg_fire, upd_fire;
    upd_kind_e            kind;

    fps_sq_pick #(.NT(NT), .NSQ(NSQ), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_pick (
        .sq_valid_i(sq_valid), .sq_tid_i(sq_tid), .sq_seq_i(sq_seq),
        .sq_tgt_i(sq_target), .hit_o(sq_hit), .seq_o(sq_seq_t), .tgt_o(sq_tgt_t)
    );

    // Decode thread commands and mark threads that take higher-priority work.
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            act_sel[t]   = act_valid   && act_tid   == TID_W'(t);
            deact_sel[t] = deact_valid && deact_tid == TID_W'(t);
            busy[t]      = act_sel[t] || deact_sel[t] || sq_hit[t];
        end
    end

    // Qualify the request ports against the addressed thread.
    assign asg_ready = thr_valid[asg_tid] && !busy[asg_tid];
    assign upd_ready = !busy[upd_tid];
    assign asg_fire  = asg_valid && asg_ready;
    assign upd_fire  = upd_valid && upd_ready;
    assign kind      = classify(upd_ctrl, upd_ret, upd_taken, upd_cond);

    // Assign result for the requesting thread.
    assign asg_pc   = pc_t[asg_tid];
    assign asg_npc  = pc_t[asg_tid] + STEP;
    assign asg_nnpc = pc_t[asg_tid] + STEP + STEP;
    assign asg_seq  = seq_t[asg_tid];

    // Flush request: after the delay slot for taken, after the branch otherwise.
    assign sqo_valid  = upd_fire && (kind == UPD_TAKEN || kind == UPD_COND_SKIP);
    assign sqo_tid    = upd_tid;
    assign sqo_seq    = (kind == UPD_TAKEN) ? upd_seq + 1'b1 : upd_seq;
    assign sqo_target = upd_target;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        fps_thread #(
            .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .STAGE_W(STAGE_W),
            .CNT_W(CNT_W), .INSN_BYTES(INSN_BYTES)
        ) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_sel[t]),
            .act_pc_i   (act_pc),
            .deact_i    (deact_sel[t]),
            .asg_i      (asg_fire && asg_tid == TID_W'(t)),
            .upd_i      (upd_fire && upd_tid == TID_W'(t)),
            .upd_kind_i (kind),
            .upd_pc_i   (upd_pc),
            .upd_tgt_i  (upd_target),
            .upd_stage_i(upd_stage),
            .sq_i       (sq_hit[t]),
            .sq_seq_i   (sq_seq_t[t*SEQ_W +: SEQ_W]),
            .sq_tgt_i   (sq_tgt_t[t*ADDR_W +: ADDR_W]),
            .pc_o       (pc_t[t]),
            .seq_o      (seq_t[t]),
            .valid_o    (thr_valid[t]),
            .stage_o    (blk_stage[t*STAGE_W +: STAGE_W]),
            .unblk_o    (unblk[t])
        );
        assign stall[t] = !thr_valid[t];
    end
endmodule

// File: rtl/fps_seq_chk.sv
// Checker for fps_seq: port-level temporal properties, bound to the top.
// Assumes the same parameter values as the bound instance.
module fps_seq_chk #(
    parameter int NT         = 4,
    parameter int NSQ        = 2,
    parameter int ADDR_W     = 32,
    parameter int SEQ_W      = 32,
    parameter int STAGE_W    = 3,
    localparam int TID_W     = $clog2(NT)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  act_valid,
    input logic                  deact_valid,
    input logic [TID_W-1:0]      deact_tid,
    input logic                  asg_valid,
    input logic [TID_W-1:0]      asg_tid,
    input logic                  asg_ready,
    input logic                  upd_valid,
    input logic [TID_W-1:0]      upd_tid,
    input logic                  upd_ready,
    input logic                  upd_ctrl,
    input logic                  upd_ret,
    input logic                  upd_taken,
    input logic                  sqo_valid,
    input logic [NSQ-1:0]        sq_valid,
    input logic [NSQ*TID_W-1:0]  sq_tid,
    input logic [NT-1:0]         stall,
    input logic [NT*STAGE_W-1:0] blk_stage,
    input logic [NT-1:0]         unblk
);
    AST_STALL_NO_ASSIGN: assert property (@(posedge clk) disable iff (!rst_n)
        asg_valid && stall[asg_tid] |-> !asg_ready); // R4

    AST_RET_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_ready && upd_ctrl && upd_ret && !upd_taken
        |=> stall[$past(upd_tid)]); // R9

    AST_SQ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid[0] && !deact_valid |=> !stall[$past(sq_tid[TID_W-1:0])]); // R10

    AST_UNBLK_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (unblk & ~stall) == '0); // R10

    AST_DEACT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        deact_valid && !act_valid |=> stall[$past(deact_tid)] &&
        blk_stage[$past(deact_tid)*STAGE_W +: STAGE_W] == '0); // R14

    AST_SQO_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        sqo_valid |-> upd_valid && upd_ready && upd_ctrl); // R5
endmodule

bind fps_seq fps_seq_chk #(
    .NT(NT), .NSQ(NSQ), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .STAGE_W(STAGE_W)
) u_chk (.*);

// File: tb/fps_seq_tb.sv
`timescale 1ns/1ps
// Bench for fps_seq at default parameters; expected values are computed
// from thread bases plus four bytes per assign and a per-thread count.
module fps_seq_tb;
    localparam int NT = 4, NSQ = 2, AW = 32, SW = 32, STW = 3, TW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic act_valid = 0, deact_valid = 0, asg_valid = 0, upd_valid = 0;
    logic [TW-1:0] act_tid = 0, deact_tid = 0, asg_tid = 0, upd_tid = 0;
    logic [AW-1:0] act_pc = 0, upd_pc = 0, upd_target = 0;
    logic upd_ctrl = 0, upd_ret = 0, upd_taken = 0, upd_cond = 0;
    logic [SW-1:0] upd_seq = 0;
    logic [STW-1:0] upd_stage = 0;
    logic [NSQ-1:0] sq_valid = 0;
    logic [NSQ*TW-1:0] sq_tid = 0;
    logic [NSQ*SW-1:0] sq_seq = 0;
    logic [NSQ*AW-1:0] sq_target = 0;
    logic asg_ready, upd_ready, sqo_valid;
    logic [AW-1:0] asg_pc, asg_npc, asg_nnpc, sqo_target;
    logic [SW-1:0] asg_seq, sqo_seq;
    logic [TW-1:0] sqo_tid;
    logic [NT-1:0] stall, unblk;
    logic [NT*STW-1:0] blk_stage;

    int total = 0, bad = 0;
    int exp_seq [NT];

    always #10 clk = ~clk;

    fps_seq u_dut (.*);

    function automatic logic [AW-1:0] base(input int t);
        return 32'h1000 + 32'h100 * t;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        act_valid = 0; deact_valid = 0; asg_valid = 0; upd_valid = 0;
        upd_ctrl = 0; upd_ret = 0; upd_taken = 0; upd_cond = 0; sq_valid = 0;
    endtask

    task automatic do_asg(input int t, input logic [AW-1:0] addr, input string tag);
        asg_valid = 1; asg_tid = TW'(t);
        #1;
        chk({tag, " ready"}, 64'(asg_ready), 64'd1);
        chk({tag, " pc"}, 64'(asg_pc), 64'(addr));
        chk({tag, " npc"}, 64'(asg_npc), 64'(addr + 4));
        chk({tag, " nnpc"}, 64'(asg_nnpc), 64'(addr + 8));
        chk({tag, " seq"}, 64'(asg_seq), 64'(exp_seq[t]));
        tick();
        asg_valid = 0;
        exp_seq[t]++;
    endtask

    task automatic set_upd(input int t, input logic c, input logic r, input logic tk,
                           input logic cd, input int s, input logic [AW-1:0] pc,
                           input logic [AW-1:0] tg, input int st);
        upd_valid = 1; upd_tid = TW'(t); upd_ctrl = c; upd_ret = r; upd_taken = tk;
        upd_cond = cd; upd_seq = SW'(s); upd_pc = pc; upd_target = tg; upd_stage = STW'(st);
    endtask

    task automatic set_sq(input int p, input int t, input logic [SW-1:0] s, input logic [AW-1:0] a);
        sq_valid[p] = 1'b1;
        sq_tid[p*TW +: TW] = TW'(t);
        sq_seq[p*SW +: SW] = s;
        sq_target[p*AW +: AW] = a;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) exp_seq[t] = 0;
        tick(); tick();
        chk("R1 stall after reset", 64'(stall), 64'hF);
        chk("R1 blk_stage after reset", 64'(blk_stage), 64'h0);
        rst_n = 1;
        tick();

        // R4: inactive thread refuses assign; sequence not consumed (checked later)
        asg_valid = 1; asg_tid = 0; #1;
        chk("R4 inactive ready", 64'(asg_ready), 64'd0);
        tick(); clr();

        // R2: activate every thread
        for (int t = 0; t < NT; t++) begin
            act_valid = 1; act_tid = TW'(t); act_pc = base(t);
            tick(); clr();
            chk("R2 stall cleared", 64'(stall[t]), 64'd0);
        end

        // R3: interleaved sequential streams on all threads
        for (int k = 0; k < 5; k++)
            for (int t = 0; t < NT; t++)
                do_asg(t, base(t) + 32'(4 * k), "R3 stream");

        // R5: taken branch at seq 4 on thread 0
        set_upd(0, 1, 0, 1, 0, 4, base(0) + 16, 32'h2000, 2); #1;
        chk("R5 sqo_valid", 64'(sqo_valid), 64'd1);
        chk("R5 sqo_seq", 64'(sqo_seq), 64'd5);
        chk("R5 sqo_target", 64'(sqo_target), 64'h2000);
        chk("R5 sqo_tid", 64'(sqo_tid), 64'd0);
        tick(); clr();
        do_asg(0, base(0) + 20, "R5 delay slot");
        do_asg(0, 32'h2000, "R5 target");
        do_asg(0, 32'h2004, "R5 after target");

        // R6: not-taken unconditional delay-slot branch on thread 1
        set_upd(1, 1, 0, 0, 0, 4, base(1) + 16, 32'h9990, 2); #1;
        chk("R6 no squash", 64'(sqo_valid), 64'd0);
        tick(); clr();
        do_asg(1, base(1) + 20, "R6 slot");
        do_asg(1, base(1) + 24, "R6 fallthrough");
        do_asg(1, base(1) + 28, "R6 next");

        // R7: conditional not-taken on thread 2
        set_upd(2, 1, 0, 0, 1, 4, base(2) + 16, 32'h3000, 2); #1;
        chk("R7 sqo_valid", 64'(sqo_valid), 64'd1);
        chk("R7 sqo_seq", 64'(sqo_seq), 64'd4);
        chk("R7 sqo_target", 64'(sqo_target), 64'h3000);
        tick(); clr();
        do_asg(2, base(2) + 20, "R7 unchanged");

        // R8: non-control update on thread 3
        set_upd(3, 0, 1, 1, 1, 4, base(3) + 16, 32'h7770, 1); #1;
        chk("R8 no squash", 64'(sqo_valid), 64'd0);
        tick(); clr();
        do_asg(3, base(3) + 20, "R8 unchanged");

        // R9/R10: return block at every stage on thread 1, released by squash
        for (int s = 0; s < 8; s++) begin
            set_upd(1, 1, 1, 0, 0, 50, 32'h0, 32'h0, s);
            tick(); clr();
            chk("R9 stalled", 64'(stall[1]), 64'd1);
            chk("R9 blk_stage", 64'(blk_stage[1*STW +: STW]), 64'(s));
            asg_valid = 1; asg_tid = 1; #1;
            chk("R9 assign refused", 64'(asg_ready), 64'd0);
            tick(); clr();
            set_sq(0, 1, 32'hFFFF_0000, 32'h4000 + 32'(16 * s)); #1;
            chk("R10 unblk pulse", 64'(unblk), 64'h2);
            tick(); clr();
            chk("R10 released", 64'(stall[1]), 64'd0);
            do_asg(1, 32'h4000 + 32'(16 * s), "R10 reload");
        end

        // R11: squash at next sequence number on thread 0 keeps the delay slot
        set_sq(1, 0, SW'(exp_seq[0]), 32'h5000); #1;
        chk("R10 no unblk on running thread", 64'(unblk), 64'd0);
        tick(); clr();
        do_asg(0, 32'h2008, "R11 slot");
        do_asg(0, 32'h5000, "R11 target");

        // R12: oldest wins, tie to lower port, cross-thread both accepted
        set_sq(0, 2, 32'd20, 32'h6000); set_sq(1, 2, 32'd10, 32'h7000);
        tick(); clr();
        do_asg(2, 32'h7000, "R12 oldest");
        set_sq(0, 2, 32'd30, 32'h8000); set_sq(1, 2, 32'd30, 32'h9000);
        tick(); clr();
        do_asg(2, 32'h8000, "R12 tie");
        set_sq(0, 3, 32'd50, 32'hA000); set_sq(1, 2, 32'd40, 32'hB000);
        tick(); clr();
        do_asg(3, 32'hA000, "R12 cross t3");
        do_asg(2, 32'hB000, "R12 cross t2");

        // R13: squash beats assign and update on the same thread
        set_sq(0, 3, 32'd60, 32'hC000);
        asg_valid = 1; asg_tid = 3;
        set_upd(3, 1, 0, 1, 0, 7, 32'h0, 32'h1234, 1); #1;
        chk("R13 asg_ready", 64'(asg_ready), 64'd0);
        chk("R13 upd_ready", 64'(upd_ready), 64'd0);
        chk("R13 no sqo", 64'(sqo_valid), 64'd0);
        tick(); clr();
        do_asg(3, 32'hC000, "R13 squash applied");
        do_asg(3, 32'hC004, "R13 no pending");

        // R14: deactivate with pending redirect and block
        set_upd(1, 1, 0, 1, 0, 99, 32'h0, 32'hEEE0, 0);
        tick(); clr();
        set_upd(1, 1, 1, 0, 0, 99, 32'h0, 32'h0, 6);
        tick(); clr();
        chk("R9 blk recorded", 64'(blk_stage[1*STW +: STW]), 64'd6);
        deact_valid = 1; deact_tid = 1;
        tick(); clr();
        chk("R14 stalled", 64'(stall[1]), 64'd1);
        chk("R14 blk_stage", 64'(blk_stage[1*STW +: STW]), 64'd0);
        asg_valid = 1; asg_tid = 1; #1;
        chk("R4 deactivated ready", 64'(asg_ready), 64'd0);
        tick(); clr();
        act_valid = 1; act_tid = 1; act_pc = 32'hD000;
        tick(); clr();
        do_asg(1, 32'hD000, "R14 restart");
        do_asg(1, 32'hD004, "R14 no redirect");
        do_asg(1, 32'hD008, "R14 sequential");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule